// File: doc/BRIEF.md
# Multicycle 8-bit CPU subset

This block is a small accumulator processor that runs six instructions. Each instruction takes a fixed number of bus cycles, and each cycle has a set job. A read or write therefore happens on a known clock edge, not all at once at the end of the instruction. The core drives one memory bus. The address and the read strobe are combinational from the sequencer state and are valid throughout the cycle. The read data returns within the same cycle. A write lands on the clock edge that ends the cycle.

An address decoder sits inside the core and turns each bus address into a select and an offset. The low 2 KiB form the RAM window. The upper 32 KiB form the program ROM window, in which a 16 KiB image repeats twice. The memories themselves sit outside the core.

After reset the core reads its start address from the two bytes at FFFC/FFFD. At each instruction boundary it checks a level-sensitive interrupt request. If the request is high, it loads the program counter from FFFA/FFFB and acknowledges the request. When the core meets an opcode it does not know, it stops for good and flags the fault. All state advances only on cycles where the clock enable is high.

Top module: `mcpu8_core`

## Requirements
- R1: Reset state and start-up.
  - While reset is low, A, X and Y read 00, S reads FD and P reads 34.
  - The first two enabled cycles after reset read FFFC and then FFFD.
  - The next cycle fetches the opcode at the address formed from those two bytes, with FFFC as the low byte.
- R2: Opcode fetch. In the first cycle of every instruction the bus address equals PC, and PC then steps by one.
- R3: Opcode A9 (load A from the next byte).
  - It takes 2 cycles.
  - Flag Z (P bit 1) is set when the result is zero.
  - Flag N (P bit 7) copies result bit 7.
- R4: Opcode 69 (add the next byte plus carry to A).
  - It takes 2 cycles.
  - It sets C (P bit 0) to the carry out.
  - It sets V (P bit 6) to signed overflow.
  - It updates Z and N from the sum.
- R5: Opcode AA (copy A into X).
  - It takes 2 cycles.
  - Its second cycle reads at PC without stepping PC.
  - It updates Z and N.
- R6: Opcode 86 (store X to a zero-page address).
  - It takes 3 cycles.
  - Cycle 2 reads the address byte.
  - Cycle 3 is the only cycle that writes. It drives address 00xx and write data equal to X.
- R7: Opcode A5 (load A from a zero-page address).
  - It takes 3 cycles.
  - Cycle 3 reads address 00xx.
  - It updates Z and N.
- R8: Opcode 4C (jump). It takes 3 cycles and reads the low target byte, then the high target byte. The next fetch happens at the target address.
- R9: Address decoding.
  - Addresses 0000-07FF assert the RAM select, with the RAM offset equal to address bits 10:0.
  - Addresses 8000-FFFF assert the ROM select, with the ROM offset equal to address bits 13:0, so C000-FFFF repeats 8000-BFFF.
  - The write strobe is asserted only inside the RAM window.
- R10: Interrupt request.
  - The request is checked only in a boundary cycle; a request raised during an instruction waits for the end of that instruction.
  - The boundary cycle reads FFFA.
  - The following cycle reads FFFB and pulses the acknowledge for one cycle.
  - The next fetch happens at the vector.
- R11: Unsupported opcodes.
  - In the cycle after an unsupported opcode's second cycle, the illegal output goes high.
  - From then on it stays high, PC and the bus address freeze, and no write occurs.
  - Only reset clears it.
- R12: When the clock enable is low, PC, registers and sequencer state hold, and no write strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| clk_en | input | 1 | Cycle enable; the core advances only when high |
| nmi_req | input | 1 | Level-sensitive interrupt request |
| nmi_ack | output | 1 | One-cycle pulse when the interrupt vector high byte is taken |
| mem_addr | output | 16 | Bus address for the current cycle |
| mem_rdata | input | 8 | Read data for the current cycle |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe, asserted only in the RAM window and only on enabled cycles |
| ram_sel | output | 1 | Address falls in the RAM window |
| ram_addr | output | 11 | RAM offset |
| rom_sel | output | 1 | Address falls in the ROM window |
| rom_addr | output | 14 | ROM offset, repeating across the window |
| illegal | output | 1 | Sticky flag for an unsupported opcode; the core halts |
| pc_o | output | 16 | Program counter |
| a_o | output | 8 | Accumulator |
| x_o | output | 8 | Index X |
| y_o | output | 8 | Index Y |
| s_o | output | 8 | Stack pointer |
| p_o | output | 8 | Status flags |

## Verification
The bus outputs (address, strobe, write data, selects and offsets) are combinational from the current sequencer state, so they are due in the cycle that uses them. The bench compares them in every enabled cycle of a reference program against a table of expected cycles.

A register result becomes visible in the cycle after the instruction's last cycle. The table therefore places register expectations on the first fetch of the following instruction. The illegal flag appears one cycle after the second cycle of an unsupported opcode. The interrupt acknowledge appears in the second vector cycle.

All comparisons are made 1 ns after a falling edge, when the previous rising edge has settled and the next has not arrived. The two-cycle reset synchronizer is counted before the first expected cycle.

// File: rtl/mcpu8_pkg.sv
package mcpu8_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_RVEC_LO,
    ST_RVEC_HI,
    ST_FETCH,
    ST_OP1,
    ST_OP2,
    ST_NVEC_HI,
    ST_HALT
  } seq_state_e;

  localparam logic [DATA_W-1:0] OP_LDA_IMM = 8'hA9;
  localparam logic [DATA_W-1:0] OP_ADC_IMM = 8'h69;
  localparam logic [DATA_W-1:0] OP_TAX     = 8'hAA;
  localparam logic [DATA_W-1:0] OP_STX_ZP  = 8'h86;
  localparam logic [DATA_W-1:0] OP_LDA_ZP  = 8'hA5;
  localparam logic [DATA_W-1:0] OP_JMP_ABS = 8'h4C;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_V = 6;
  localparam int FLG_N = 7;

  localparam logic [ADDR_W-1:0] VEC_START = 16'hFFFC;
  localparam logic [ADDR_W-1:0] VEC_INTR  = 16'hFFFA;

  localparam logic [DATA_W-1:0] P_INIT = 8'h34;
  localparam logic [DATA_W-1:0] S_INIT = 8'hFD;

endpackage

// File: rtl/mcpu8_alu.sv
module mcpu8_alu
  import mcpu8_pkg::*;
(
  input  logic              use_add,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output logic              c_out,
  output logic              v_out,
  output logic              z_out,
  output logic              n_out
);

  logic [DATA_W:0] sum;

  always_comb begin
    sum   = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, c_in};
    res   = use_add ? sum[DATA_W-1:0] : b_in;
    c_out = sum[DATA_W];
    v_out = (~(a_in[DATA_W-1] ^ b_in[DATA_W-1])) & (a_in[DATA_W-1] ^ sum[DATA_W-1]);
    z_out = (res == '0);
    n_out = res[DATA_W-1];
  end

endmodule

// File: rtl/mcpu8_addr_dec.sv
module mcpu8_addr_dec
  import mcpu8_pkg::*;
#(
  parameter int RAM_AW = 11,
  parameter int ROM_AW = 14
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              clk_en,
  output logic              ram_sel,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              rom_sel,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              we
);

  localparam int RAM_TAG_W = ADDR_W - RAM_AW;

  always_comb begin
    ram_sel  = (addr[ADDR_W-1:RAM_AW] == {RAM_TAG_W{1'b0}});
    ram_addr = addr[RAM_AW-1:0];
    rom_sel  = addr[ADDR_W-1];
    rom_addr = addr[ROM_AW-1:0];
    we       = wr & ram_sel & clk_en;
  end

endmodule

// File: rtl/mcpu8_seq.sv
module mcpu8_seq
  import mcpu8_pkg::*;
(
  input  seq_state_e        state_q,
  input  logic [DATA_W-1:0] op_q,
  input  logic [DATA_W-1:0] tmp_q,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic              nmi_req,
  output seq_state_e        state_d,
  output logic [ADDR_W-1:0] addr,
  output logic              wr,
  output logic              ld_tmp,
  output logic              ld_op,
  output logic              pc_inc,
  output logic              pc_load,
  output logic              ld_a,
  output logic              ld_x,
  output logic              set_nz,
  output logic              set_cv,
  output logic              use_add,
  output logic              b_from_a,
  output logic              ack
);

  localparam logic [ADDR_W-1:0] ONE = 16'd1;

  always_comb begin
    state_d  = state_q;
    addr     = pc_q;
    wr       = 1'b0;
    ld_tmp   = 1'b0;
    ld_op    = 1'b0;
    pc_inc   = 1'b0;
    pc_load  = 1'b0;
    ld_a     = 1'b0;
    ld_x     = 1'b0;
    set_nz   = 1'b0;
    set_cv   = 1'b0;
    use_add  = 1'b0;
    b_from_a = 1'b0;
    ack      = 1'b0;
    unique case (state_q)
      ST_RVEC_LO: begin
        addr    = VEC_START;
        ld_tmp  = 1'b1;
        state_d = ST_RVEC_HI;
      end
      ST_RVEC_HI: begin
        addr    = VEC_START + ONE;
        pc_load = 1'b1;
        state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (nmi_req) begin
          addr    = VEC_INTR;
          ld_tmp  = 1'b1;
          state_d = ST_NVEC_HI;
        end else begin
          ld_op   = 1'b1;
          pc_inc  = 1'b1;
          state_d = ST_OP1;
        end
      end
      ST_NVEC_HI: begin
        addr    = VEC_INTR + ONE;
        pc_load = 1'b1;
        ack     = 1'b1;
        state_d = ST_FETCH;
      end
      ST_OP1: begin
        unique case (op_q)
          OP_LDA_IMM: begin
            ld_a = 1'b1; set_nz = 1'b1; pc_inc = 1'b1; state_d = ST_FETCH;
          end
          OP_ADC_IMM: begin
            ld_a = 1'b1; set_nz = 1'b1; set_cv = 1'b1; use_add = 1'b1;
            pc_inc = 1'b1; state_d = ST_FETCH;
          end
          OP_TAX: begin
            ld_x = 1'b1; set_nz = 1'b1; b_from_a = 1'b1; state_d = ST_FETCH;
          end
          OP_STX_ZP, OP_LDA_ZP, OP_JMP_ABS: begin
            ld_tmp = 1'b1; pc_inc = 1'b1; state_d = ST_OP2;
          end
          default: state_d = ST_HALT;
        endcase
      end
      ST_OP2: begin
        unique case (op_q)
          OP_STX_ZP: begin
            addr = {8'h00, tmp_q}; wr = 1'b1; state_d = ST_FETCH;
          end
          OP_LDA_ZP: begin
            addr = {8'h00, tmp_q}; ld_a = 1'b1; set_nz = 1'b1; state_d = ST_FETCH;
          end
          OP_JMP_ABS: begin
            pc_load = 1'b1; state_d = ST_FETCH;
          end
          default: state_d = ST_HALT;
        endcase
      end
      default: state_d = ST_HALT;
    endcase
  end

endmodule

// File: rtl/mcpu8_core.sv
module mcpu8_core
  import mcpu8_pkg::*;
#(
  parameter int RAM_AW = 11,
  parameter int ROM_AW = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              nmi_req,
  output logic              nmi_ack,
  output logic [15:0]       mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              ram_sel,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              rom_sel,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              illegal,
  output logic [15:0]       pc_o,
  output logic [7:0]        a_o,
  output logic [7:0]        x_o,
  output logic [7:0]        y_o,
  output logic [7:0]        s_o,
  output logic [7:0]        p_o
);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] a_q, a_d, x_q, x_d, y_q, s_q, p_q, p_d, op_q, op_d, tmp_q, tmp_d;

  logic              wr, ld_tmp, ld_op, pc_inc, pc_load, ld_a, ld_x;
  logic              set_nz, set_cv, use_add, b_from_a, ack;
  logic [DATA_W-1:0] alu_res;
  logic              alu_c, alu_v, alu_z, alu_n;

  mcpu8_seq u_seq (
    .state_q  (state_q),
    .op_q     (op_q),
    .tmp_q    (tmp_q),
    .pc_q     (pc_q),
    .nmi_req  (nmi_req),
    .state_d  (state_d),
    .addr     (mem_addr),
    .wr       (wr),
    .ld_tmp   (ld_tmp),
    .ld_op    (ld_op),
    .pc_inc   (pc_inc),
    .pc_load  (pc_load),
    .ld_a     (ld_a),
    .ld_x     (ld_x),
    .set_nz   (set_nz),
    .set_cv   (set_cv),
    .use_add  (use_add),
    .b_from_a (b_from_a),
    .ack      (ack)
  );

  mcpu8_alu u_alu (
    .use_add (use_add),
    .a_in    (a_q),
    .b_in    (b_from_a ? a_q : mem_rdata),
    .c_in    (p_q[FLG_C]),
    .res     (alu_res),
    .c_out   (alu_c),
    .v_out   (alu_v),
    .z_out   (alu_z),
    .n_out   (alu_n)
  );

  mcpu8_addr_dec #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW)) u_dec (
    .addr     (mem_addr),
    .wr       (wr),
    .clk_en   (clk_en),
    .ram_sel  (ram_sel),
    .ram_addr (ram_addr),
    .rom_sel  (rom_sel),
    .rom_addr (rom_addr),
    .we       (mem_we)
  );

  // next-state values for the architectural registers
  always_comb begin
    pc_d  = pc_q;
    a_d   = a_q;
    x_d   = x_q;
    p_d   = p_q;
    op_d  = op_q;
    tmp_d = tmp_q;
    if (pc_load)     pc_d = {mem_rdata, tmp_q};
    else if (pc_inc) pc_d = pc_q + 16'd1;
    if (ld_a)   a_d   = alu_res;
    if (ld_x)   x_d   = alu_res;
    if (ld_op)  op_d  = mem_rdata;
    if (ld_tmp) tmp_d = mem_rdata;
    if (set_nz) begin
      p_d[FLG_Z] = alu_z;
      p_d[FLG_N] = alu_n;
    end
    if (set_cv) begin
      p_d[FLG_C] = alu_c;
      p_d[FLG_V] = alu_v;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_RVEC_LO;
      pc_q    <= '0;
      a_q     <= '0;
      x_q     <= '0;
      y_q     <= '0;
      s_q     <= S_INIT;
      p_q     <= P_INIT;
      op_q    <= '0;
      tmp_q   <= '0;
    end else if (clk_en) begin
      state_q <= state_d;
      pc_q    <= pc_d;
      a_q     <= a_d;
      x_q     <= x_d;
      p_q     <= p_d;
      op_q    <= op_d;
      tmp_q   <= tmp_d;
    end
  end

  assign nmi_ack   = ack & clk_en;
  assign mem_wdata = x_q;
  assign illegal   = (state_q == ST_HALT);
  assign pc_o      = pc_q;
  assign a_o       = a_q;
  assign x_o       = x_q;
  assign y_o       = y_q;
  assign s_o       = s_q;
  assign p_o       = p_q;

endmodule

// File: rtl/mcpu8_core_chk.sv
module mcpu8_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clk_en,
  input logic        nmi_ack,
  input logic [15:0] mem_addr,
  input logic        mem_we,
  input logic        ram_sel,
  input logic        rom_sel,
  input logic        illegal,
  input logic [15:0] pc_o,
  input logic [7:0]  a_o,
  input logic [7:0]  x_o,
  input logic [7:0]  p_o
);

  a_r6_write_zero_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] == 8'h00));

  a_r9_write_in_ram: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ram_sel);

  a_r9_windows_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_sel && rom_sel));

  a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |=> !nmi_ack);

  a_r10_ack_at_vector: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |-> (mem_addr == 16'hFFFB));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> ($stable(pc_o) && !mem_we));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(pc_o) && $stable(a_o) && $stable(x_o) && $stable(p_o)));

  a_r12_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !mem_we);

endmodule

bind mcpu8_core mcpu8_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_en   (clk_en),
  .nmi_ack  (nmi_ack),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .ram_sel  (ram_sel),
  .rom_sel  (rom_sel),
  .illegal  (illegal),
  .pc_o     (pc_o),
  .a_o      (a_o),
  .x_o      (x_o),
  .p_o      (p_o)
);

// File: tb/mcpu8_core_tb.sv
module mcpu8_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        nmi_req = 1'b0;
  logic        nmi_ack;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        ram_sel;
  logic [10:0] ram_addr;
  logic        rom_sel;
  logic [13:0] rom_addr;
  logic        illegal;
  logic [15:0] pc_o;
  logic [7:0]  a_o, x_o, y_o, s_o, p_o;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mcpu8_core u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .nmi_req(nmi_req), .nmi_ack(nmi_ack),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .ram_sel(ram_sel), .ram_addr(ram_addr), .rom_sel(rom_sel), .rom_addr(rom_addr),
    .illegal(illegal), .pc_o(pc_o), .a_o(a_o), .x_o(x_o), .y_o(y_o), .s_o(s_o), .p_o(p_o)
  );

  // program image: offset 0 is 8000 (and C000 through the repeat)
  localparam logic [7:0] PROG [0:35] = '{
    8'hA9, 8'h05, 8'h69, 8'h06, 8'hAA, 8'h86, 8'h01, 8'hA5,
    8'h01, 8'hA9, 8'h7F, 8'h69, 8'h01, 8'h69, 8'h80, 8'h69,
    8'h00, 8'hAA, 8'h86, 8'h10, 8'h4C, 8'h18, 8'hC0, 8'h00,
    8'hA5, 8'h10, 8'h4C, 8'h1A, 8'hC0, 8'h00, 8'h00, 8'h00,
    8'hA9, 8'h00, 8'h02, 8'h00
  };

  function automatic logic [7:0] rom_byte(input logic [13:0] off);
    if (off < 14'd36) return PROG[off[5:0]];
    case (off)
      14'h3FFA: return 8'h20;
      14'h3FFB: return 8'h80;
      14'h3FFC: return 8'h00;
      14'h3FFD: return 8'h80;
      default:  return 8'hEA;
    endcase
  endfunction

  logic [7:0] ram_m [0:2047];

  always_comb begin
    if (ram_sel)      mem_rdata = ram_m[ram_addr];
    else if (rom_sel) mem_rdata = rom_byte(rom_addr);
    else              mem_rdata = 8'h00;
  end

  always @(posedge clk) if (mem_we) ram_m[ram_addr] <= mem_wdata;

  typedef struct packed {
    logic [15:0] addr;
    logic        we;
    logic [7:0]  wd;
    logic        chk;
    logic [7:0]  a;
    logic [7:0]  x;
    logic [7:0]  p;
    logic [3:0]  req;
  } trace_t;

  // expected bus cycles; register values are those visible during the cycle
  localparam trace_t TRACE [0:36] = '{
    '{16'hFFFC,1'b0,8'h00,1'b1,8'h00,8'h00,8'h34,4'd1},  // R1 start vector low
    '{16'hFFFD,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd1},  // R1 start vector high
    '{16'h8000,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd2},  // R2 fetch A9
    '{16'h8001,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd3},  // R3
    '{16'h8002,1'b0,8'h00,1'b1,8'h05,8'h00,8'h34,4'd3},  // R3 A=05
    '{16'h8003,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd4},  // R4
    '{16'h8004,1'b0,8'h00,1'b1,8'h0B,8'h00,8'h34,4'd4},  // R4 05+06
    '{16'h8005,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd5},  // R5 read without step
    '{16'h8005,1'b0,8'h00,1'b1,8'h0B,8'h0B,8'h34,4'd5},  // R5 X=0B
    '{16'h8006,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd6},  // R6 address byte
    '{16'h0001,1'b1,8'h0B,1'b0,8'h00,8'h00,8'h00,4'd6},  // R6 write
    '{16'h8007,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd7},  // R7
    '{16'h8008,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd7},
    '{16'h0001,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd7},  // R7 zero-page read
    '{16'h8009,1'b0,8'h00,1'b1,8'h0B,8'h0B,8'h34,4'd7},
    '{16'h800A,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd3},
    '{16'h800B,1'b0,8'h00,1'b1,8'h7F,8'h0B,8'h34,4'd3},  // R3 A=7F
    '{16'h800C,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd4},
    '{16'h800D,1'b0,8'h00,1'b1,8'h80,8'h0B,8'hF4,4'd4},  // R4 overflow, N
    '{16'h800E,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd4},
    '{16'h800F,1'b0,8'h00,1'b1,8'h00,8'h0B,8'h77,4'd4},  // R4 carry, zero, V
    '{16'h8010,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd4},
    '{16'h8011,1'b0,8'h00,1'b1,8'h01,8'h0B,8'h34,4'd4},  // R4 carry in used
    '{16'h8012,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd5},
    '{16'h8012,1'b0,8'h00,1'b1,8'h01,8'h01,8'h34,4'd5},
    '{16'h8013,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd6},
    '{16'h0010,1'b1,8'h01,1'b0,8'h00,8'h00,8'h00,4'd6},  // R6 second store
    '{16'h8014,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd8},  // R8 jump
    '{16'h8015,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd8},
    '{16'h8016,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd8},
    '{16'hC018,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd8},  // R8 target, R9 repeat
    '{16'hC019,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd7},
    '{16'h0010,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd7},
    '{16'hC01A,1'b0,8'h00,1'b1,8'h01,8'h01,8'h34,4'd7},
    '{16'hC01B,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd8},
    '{16'hC01C,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd8},
    '{16'hC01A,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,4'd8}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] hold_addr, hold_pc;
    logic [7:0]  hold_a;
    bit          found;
    for (int i = 0; i < 2048; i++) ram_m[i] = 8'h00;

    // R1 reset values
    repeat (3) @(negedge clk);
    #1;
    check(a_o == 8'h00 && x_o == 8'h00 && y_o == 8'h00, "R1", "A/X/Y in reset",
          {a_o, x_o}, 16'h0000);
    check(s_o == 8'hFD && p_o == 8'h34, "R1", "S/P in reset", {s_o, p_o}, 16'hFD34);
    check(!illegal && !mem_we && !nmi_ack, "R1", "idle outputs in reset",
          {13'd0, illegal, mem_we, nmi_ack}, 16'h0000);

    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 37; i++) begin
      trace_t t;
      string  rq;
      t  = TRACE[i];
      rq = $sformatf("R%0d", t.req);
      cyc();
      check(mem_addr == t.addr, rq, $sformatf("trace %0d address", i), mem_addr, t.addr);
      check(mem_we == t.we, rq, $sformatf("trace %0d strobe", i), {15'd0, mem_we}, {15'd0, t.we});
      if (t.we)
        check(mem_wdata == t.wd, rq, $sformatf("trace %0d wdata", i), {8'd0, mem_wdata}, {8'd0, t.wd});
      if (t.chk) begin
        check(a_o == t.a, rq, $sformatf("trace %0d A", i), {8'd0, a_o}, {8'd0, t.a});
        check(x_o == t.x, rq, $sformatf("trace %0d X", i), {8'd0, x_o}, {8'd0, t.x});
        check(p_o == t.p, rq, $sformatf("trace %0d P", i), {8'd0, p_o}, {8'd0, t.p});
      end
      // R9 decode of every address seen
      check(ram_sel == (t.addr < 16'h0800) && rom_sel == t.addr[15], "R9",
            $sformatf("trace %0d selects", i), {14'd0, ram_sel, rom_sel},
            {14'd0, (t.addr < 16'h0800), t.addr[15]});
      if (t.addr[15])
        check(rom_addr == t.addr[13:0], "R9", $sformatf("trace %0d rom offset", i),
              {2'd0, rom_addr}, {2'd0, t.addr[13:0]});
      if (t.addr < 16'h0800)
        check(ram_addr == t.addr[10:0], "R9", $sformatf("trace %0d ram offset", i),
              {5'd0, ram_addr}, {5'd0, t.addr[10:0]});
    end
    check(ram_m[1] == 8'h0B, "R6", "memory at 0001", {8'd0, ram_m[1]}, 16'h000B);
    check(ram_m[16] == 8'h01, "R6", "memory at 0010", {8'd0, ram_m[16]}, 16'h0001);

    // R12 clock enable low holds everything
    clk_en = 1'b0;
    #1;
    hold_addr = mem_addr;
    hold_pc   = pc_o;
    hold_a    = a_o;
    for (int k = 0; k < 4; k++) begin
      cyc();
      check(mem_addr == hold_addr && pc_o == hold_pc, "R12", "stall address/PC",
            pc_o, hold_pc);
      check(!mem_we && a_o == hold_a, "R12", "stall write/A", {7'd0, mem_we, a_o},
            {8'd0, hold_a});
    end
    clk_en = 1'b1;

    // R10 request raised mid-instruction waits for the boundary
    found = 1'b0;
    for (int k = 0; k < 8 && !found; k++) begin
      cyc();
      if (mem_addr == 16'hC01B) found = 1'b1;
    end
    check(found, "R10", "reached jump operand cycle", mem_addr, 16'hC01B);
    nmi_req = 1'b1;
    cyc();
    check(mem_addr == 16'hC01C && !nmi_ack, "R10", "instruction finishes first",
          mem_addr, 16'hC01C);
    cyc();
    check(mem_addr == 16'hFFFA && !nmi_ack, "R10", "vector low cycle", mem_addr, 16'hFFFA);
    cyc();
    check(mem_addr == 16'hFFFB, "R10", "vector high cycle", mem_addr, 16'hFFFB);
    check(nmi_ack, "R10", "acknowledge pulse", {15'd0, nmi_ack}, 16'h0001);
    nmi_req = 1'b0;
    cyc();
    check(mem_addr == 16'h8020 && !nmi_ack, "R10", "fetch at vector", mem_addr, 16'h8020);
    cyc();
    cyc();
    check(mem_addr == 16'h8022, "R2", "fetch after handler load", mem_addr, 16'h8022);
    check(a_o == 8'h00 && p_o == 8'h36, "R3", "zero load sets Z", {a_o, p_o}, 16'h0036);

    // R11 unsupported opcode 02
    cyc();
    check(mem_addr == 16'h8023 && !illegal, "R11", "second cycle not yet flagged",
          {illegal, mem_addr[14:0]}, 16'h0023);
    cyc();
    check(illegal, "R11", "flag raised", {15'd0, illegal}, 16'h0001);
    for (int k = 0; k < 6; k++) cyc();
    check(illegal && mem_addr == 16'h8023 && pc_o == 16'h8023 && !mem_we, "R11",
          "still halted", pc_o, 16'h8023);

    // R1 reset clears the halt and restarts from the vector
    rst_n = 1'b0;
    #1;
    check(!illegal, "R1", "reset clears halt", {15'd0, illegal}, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    cyc();
    check(mem_addr == 16'hFFFC, "R1", "restart vector low", mem_addr, 16'hFFFC);
    cyc();
    check(mem_addr == 16'hFFFD, "R1", "restart vector high", mem_addr, 16'hFFFD);
    cyc();
    check(mem_addr == 16'h8000 && pc_o == 16'h8000, "R1", "restart fetch", mem_addr, 16'h8000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule